// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Selectable Synchronizer Depth

This block moves data words from a producer clocked by one clock to a consumer clocked by a second clock. The two clocks need have no relationship. There is no acknowledge for each word. The producer offers a word with a strobe and stops only when the full flag tells it to. The consumer sees the oldest stored word with a valid flag and takes it by raising its ready input. Storage is a small register array written in the producer domain and read in the consumer domain.

Each side keeps a position counter one bit wider than the storage address. The counter is Gray-coded before it is passed to the other domain. Each crossing goes through a chain of flops whose length is picked by a configuration input, from none up to four. More stages give a safer crossing; fewer stages give a shorter delay. A setting of zero routes the Gray count straight across, which is only legal when both sides run on the same clock.

The configuration is captured only while a domain's internal reset is held. Each domain has its own active-low reset. The reset is applied at once and released in step with that domain's clock.

Top module: `xfifo_dual_clk`

## Requirements
- R1: While a domain's reset is held, and on the first cycles after it is released, `wr_full` is 0 and `rd_valid` is 0.
- R2: Between two unrelated clocks, every accepted word reaches the consumer exactly once, in the order it was written, with its value unchanged.
- R3: After DEPTH (default 32) accepted words with no reads, `wr_full` is 1. A write attempted while `wr_full` is 1 is dropped and does not change the stored contents or their order.
- R4: Raising `rd_ready` while `rd_valid` is 0 has no effect. A word written afterwards is the next one presented.
- R5: With both sides on one clock and a setting of N from 0 to 4, `rd_valid` rises N consumer clock edges after the edge that accepts a word into an empty FIFO. Settings 5 to 7 behave as 4.
- R6: Changing `sync_stages` while the resets are released has no effect. The depth captured during the last reset stays in force.
- R7: While the FIFO is neither full nor empty, one word is accepted and one word is delivered on every cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_arst_n | input | 1 | Producer reset, active low, asynchronous assert |
| wr_valid | input | 1 | Producer offers `wr_data` this cycle |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | No space left; offered words are dropped |
| rd_clk | input | 1 | Consumer clock |
| rd_arst_n | input | 1 | Consumer reset, active low, asynchronous assert |
| rd_ready | input | 1 | Consumer takes the presented word at this edge |
| rd_valid | output | 1 | `rd_data` holds a stored word |
| rd_data | output | WIDTH | Oldest stored word |
| sync_stages | input | 3 | Synchronizer length, 0 to 4, captured during reset |

## Verification
The hardest case to reach is the full boundary. It needs a write to be offered while the synchronized read position says the memory is full. With a reader that never drains, this is reached by writing past DEPTH on consecutive cycles, and the dropped words are then shown to be missing from the drained sequence. The delay for each synchronizer setting can only be seen cycle by cycle when both sides share a clock. So a table of settings and expected delays is walked with the two clocks tied together. A separate run then uses a consumer clock with an unrelated period and irregular valid and ready patterns, which exercises the Gray crossings in both directions.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int unsigned SYNC_MAX = 4;
  localparam int unsigned SEL_W    = 3;

  typedef logic [SEL_W-1:0] sync_sel_t;

  // Settings above the longest chain select the longest chain.
  function automatic sync_sel_t clamp_sel(input sync_sel_t s);
    return (s > sync_sel_t'(SYNC_MAX)) ? sync_sel_t'(SYNC_MAX) : s;
  endfunction
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 2'b00;
    else         q <= {q[0], 1'b1};
  end

  assign rst_n_s = q[1];
endmodule

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync
  import xfifo_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sync_sel_t sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [SYNC_MAX-1:0][W-1:0] stage_q, stage_n;

  always_comb begin
    stage_n = {stage_q[SYNC_MAX-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_n;
  end

  // Tap mux: setting 0 passes the input straight through.
  logic [SYNC_MAX:0][W-1:0] taps;
  assign taps[0] = d;
  generate
    for (genvar i = 0; i < SYNC_MAX; i++) begin : g_tap
      assign taps[i+1] = stage_q[i];
    end
  endgenerate

  assign q = taps[sel];
endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side #(
  parameter int unsigned AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [AW:0] rgray_s,
  output logic        wen,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        full
);
  logic [AW:0] wbin_q, wbin_n, wgray_q, wgray_n;

  // Full: the top two Gray bits are inverted and the rest match.
  assign full  = (wgray_q == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign wen   = wr_valid & ~full;
  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;

  always_comb begin
    wbin_n  = wbin_q + {{AW{1'b0}}, 1'b1};
    wgray_n = wbin_n ^ (wbin_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wen) begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
    end
  end
endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side #(
  parameter int unsigned AW = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_ready,
  input  logic [AW:0] wgray_s,
  output logic        ren,
  output logic [AW-1:0] raddr,
  output logic [AW:0] rgray,
  output logic        empty
);
  logic [AW:0] rbin_q, rbin_n, rgray_q, rgray_n;

  assign empty = (rgray_q == wgray_s);
  assign ren   = rd_ready & ~empty;
  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;

  always_comb begin
    rbin_n  = rbin_q + {{AW{1'b0}}, 1'b1};
    rgray_n = rbin_n ^ (rbin_n >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (ren) begin
      rbin_q  <= rbin_n;
      rgray_q <= rgray_n;
    end
  end
endmodule

// File: rtl/xfifo_dual_clk.sv
module xfifo_dual_clk
  import xfifo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic             wr_clk,
  input  logic             wr_arst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_full,
  input  logic             rd_clk,
  input  logic             rd_arst_n,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic [2:0]       sync_stages
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic wr_rst_s, rd_rst_s;
  xfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_arst_n), .rst_n_s(wr_rst_s));
  xfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_arst_n), .rst_n_s(rd_rst_s));

  // Depth selects: loaded only while the domain's internal reset is held.
  sync_sel_t wr_sel_q, rd_sel_q;
  always_ff @(posedge wr_clk) begin
    if (!wr_rst_s) wr_sel_q <= clamp_sel(sync_stages);
  end
  always_ff @(posedge rd_clk) begin
    if (!rd_rst_s) rd_sel_q <= clamp_sel(sync_stages);
  end

  logic          wen, ren, empty;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  xfifo_wr_side #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_s), .wr_valid(wr_valid), .rgray_s(rgray_s),
    .wen(wen), .waddr(waddr), .wgray(wgray), .full(wr_full)
  );

  xfifo_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_s), .rd_ready(rd_ready), .wgray_s(wgray_s),
    .ren(ren), .raddr(raddr), .rgray(rgray), .empty(empty)
  );

  xfifo_ptr_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_s), .sel(rd_sel_q), .d(wgray), .q(wgray_s)
  );

  xfifo_ptr_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_s), .sel(wr_sel_q), .d(rgray), .q(rgray_s)
  );

  logic [WIDTH-1:0] mem [DEPTH];
  always_ff @(posedge wr_clk) begin
    if (wen) mem[waddr] <= wr_data;
  end

  assign rd_data  = mem[raddr];
  assign rd_valid = ~empty;
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int unsigned PW = 6
) (
  input logic          wr_clk,
  input logic          wr_rst_s,
  input logic          rd_clk,
  input logic          rd_rst_s,
  input logic          wr_valid,
  input logic          wr_full,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [2:0]    wr_sel,
  input logic [2:0]    rd_sel
);
  // R2: each crossing count moves by at most one bit per cycle
  assert_wgray_step_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    $countones(wgray ^ $past(wgray)) <= 1);
  assert_rgray_step_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R2: a presented word stays presented until it is taken
  assert_valid_holds_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    (rd_valid && !rd_ready) |=> rd_valid);

  // R3: a write offered while full leaves the write count alone
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    (wr_valid && wr_full) |=> $stable(wgray));

  // R3: full cannot appear without a write
  assert_full_needs_write_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    (!wr_full && !wr_valid) |=> !wr_full);

  // R4: a read request while empty leaves the read count alone
  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    (rd_ready && !rd_valid) |=> $stable(rgray));

  // R6: captured depth holds while out of reset
  assert_wsel_frozen_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_s)
    $past(wr_rst_s) |-> $stable(wr_sel));
  assert_rsel_frozen_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_s)
    $past(rd_rst_s) |-> $stable(rd_sel));
endmodule

bind xfifo_dual_clk xfifo_chk #(.PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_s(wr_rst_s), .rd_clk(rd_clk), .rd_rst_s(rd_rst_s),
  .wr_valid(wr_valid), .wr_full(wr_full), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .wgray(wgray), .rgray(rgray), .wr_sel(wr_sel_q), .rd_sel(rd_sel_q)
);

// File: tb/tb_xfifo_dual_clk.sv
module tb_xfifo_dual_clk;
  localparam int DEPTH = 32;

  logic clk = 1'b0, clk2 = 1'b0, async_mode = 1'b0;
  always #5 clk = ~clk;
  always #7 clk2 = ~clk2;
  wire rd_clk = async_mode ? clk2 : clk;

  logic       wr_arst_n = 1'b0, rd_arst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] sync_stages = 3'd2;
  logic       wr_full, rd_valid;
  logic [7:0] rd_data;

  xfifo_dual_clk #(.WIDTH(8), .DEPTH(DEPTH)) dut (
    .wr_clk(clk), .wr_arst_n(wr_arst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_arst_n(rd_arst_n), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .sync_stages(sync_stages)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {setting, expected delay}, octal digits
  localparam logic [5:0] LAT_TAB [7] = '{6'o00, 6'o11, 6'o22, 6'o33, 6'o44, 6'o54, 6'o74};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] cfg, input logic am);
    wr_valid = 1'b0; rd_ready = 1'b0;
    wr_arst_n = 1'b0; rd_arst_n = 1'b0;
    sync_stages = cfg; async_mode = am;
    repeat (6) @(posedge clk);
    @(negedge clk);
    wr_arst_n = 1'b1; rd_arst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // Write one word into an empty FIFO, count clock edges until it shows, read it out.
  task automatic measure(input logic [7:0] v, output int lat, output int dat);
    @(negedge clk);
    wr_data = v; wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    lat = 0;
    while (!rd_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    dat = int'(rd_data);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    int lat, dat, acc, got, bad, stalls, sent, rc;

    // R1: reset state
    do_reset(3'd2, 1'b0);
    check(!rd_valid, "R1 rd_valid", int'(rd_valid), 0);
    check(!wr_full, "R1 wr_full", int'(wr_full), 0);

    // R5: delay table walk
    for (int i = 0; i < 7; i++) begin
      do_reset(LAT_TAB[i][5:3], 1'b0);
      measure(8'(8'h30 + i), lat, dat);
      check(lat == int'(LAT_TAB[i][2:0]), "R5 delay", lat, int'(LAT_TAB[i][2:0]));
      check(dat == 8'h30 + i, "R5 data", dat, 8'h30 + i);
    end

    // R6: change setting after reset, old depth stays
    do_reset(3'd3, 1'b0);
    @(negedge clk);
    sync_stages = 3'd0;
    measure(8'h77, lat, dat);
    check(lat == 3, "R6 delay after runtime change", lat, 3);

    // R3: fill past DEPTH with no reads
    do_reset(3'd2, 1'b0);
    check(!wr_full && !rd_valid, "R1 idle after reset", int'(wr_full), 0);
    acc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wr_data = 8'(i); wr_valid = 1'b1;
      if (!wr_full) acc++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    check(acc == DEPTH, "R3 accepted count", acc, DEPTH);
    check(wr_full, "R3 full flag", int'(wr_full), 1);
    got = 0; bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rd_valid) break;
      if (int'(rd_data) != got) bad++;
      rd_ready = 1'b1;
      got++;
    end
    rd_ready = 1'b0;
    check(got == DEPTH, "R3 drained count", got, DEPTH);
    check(bad == 0, "R3 drained order", bad, 0);

    // R4: reads while empty are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rd_ready = 1'b1;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    check(!rd_valid, "R4 still empty", int'(rd_valid), 0);
    measure(8'hA5, lat, dat);
    check(dat == 8'hA5, "R4 next word", dat, 8'hA5);
    check(lat == 2, "R4 delay", lat, 2);

    // R7: steady one-per-cycle
    do_reset(3'd1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_data = 8'(i); wr_valid = 1'b1;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (4) @(negedge clk);
    stalls = 0; bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!rd_valid || wr_full) stalls++;
      else if (int'(rd_data) != k) bad++;
      wr_data = 8'(4 + k); wr_valid = 1'b1; rd_ready = 1'b1;
    end
    @(negedge clk);
    wr_valid = 1'b0; rd_ready = 1'b0;
    check(stalls == 0, "R7 stalls", stalls, 0);
    check(bad == 0, "R7 order", bad, 0);

    // R2: unrelated clocks, irregular traffic
    do_reset(3'd2, 1'b1);
    sent = 0; got = 0; bad = 0; rc = 0;
    fork
      begin
        int cyc = 0;
        while (sent < 60) begin
          @(negedge clk);
          wr_valid = (cyc % 4 != 3);
          wr_data  = 8'(sent + 8'h40);
          if (wr_valid && !wr_full) sent++;
          cyc++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
      end
      begin
        while (got < 60 && rc < 3000) begin
          @(negedge clk2);
          rd_ready = (rc % 5 != 2);
          if (rd_ready && rd_valid) begin
            if (int'(rd_data) != got + 8'h40) bad++;
            got++;
          end
          rc++;
        end
        @(negedge clk2);
        rd_ready = 1'b0;
      end
    join
    check(got == 60, "R2 received count", got, 60);
    check(bad == 0, "R2 value order", bad, 0);
    repeat (4) @(negedge clk2);
    check(!rd_valid, "R2 nothing extra", int'(rd_valid), 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule